// File: doc/BRIEF.md
# Output Compare and PWM Channel

This block is one timer-driven output channel. It compares the count of one of two free-running 16-bit timers against two 16-bit registers. The result drives a set/reset output flip-flop that feeds a pin. A control write picks the timer, the operating mode and the output enable. The channel has three groups of modes:

- **Single-match modes** drive the pin high, drive it low, or toggle it when the count equals the main register.
- **Dual-match modes** build a pulse. The pin rises on a secondary-register match and falls on the following main-register match. The pulse is produced once or repeated.
- **PWM modes** use the main register as a writable duty master. The secondary register becomes a slave copy that is refreshed only at the selected timer's period strobe, so a duty change never splits a period. One PWM mode honours a fault input that forces the pin low and latches a status bit.

The channel is controlled by a state machine with these states:

| State | Meaning |
|---|---|
| ST_OFF | Channel disabled |
| ST_ARM | Waiting for a single match |
| ST_RISE | Waiting for the secondary match |
| ST_FALL | Waiting for the main match |
| ST_DONE | Finished, output frozen |
| ST_PWM | PWM running |
| ST_FAULT | PWM stopped by a fault |

Its transitions are:

- A control write enters the initial state of the new mode from any state: ST_OFF, ST_ARM, ST_RISE or ST_PWM.
- ST_ARM moves to ST_DONE on a main match in the drive-high and drive-low modes. In toggle mode it stays in ST_ARM.
- ST_RISE moves to ST_FALL on a secondary match.
- ST_FALL moves on a main match: to ST_DONE in single-pulse mode, or back to ST_RISE in continuous-pulse mode.
- ST_PWM moves to ST_FAULT when the fault input is high in the fault-enabled PWM mode.
- ST_OFF, ST_DONE and ST_FAULT stay where they are until the next control write.

Top module: `oc_pwm_channel`

## Requirements
- R1: After reset the pin, the pin enable, the interrupt flag and the fault status are all 0, and the mode is 000 (disabled).
- R2: With the select bit 0 the channel uses timer A's count and period strobe; with 1 it uses timer B's. The unselected timer has no effect on the pin.
- R3: Mode 001 drives the pin high on the first cycle the count equals the main register; the pin then stays high until the next control write.
- R4: Mode 010 sets the pin high when the mode is written and drives it low on the first main-register match; it then stays low.
- R5: Mode 011 inverts the pin on every main-register match.
- R6: Mode 100 raises the pin on a secondary-register match and lowers it on the next main-register match; after that the pin stays low.
- R7: Mode 101 behaves as mode 100 but re-arms after each fall, giving a pulse train.
- R8: In modes 110 and 111, the selected period strobe copies the main register into the secondary register and sets the pin high. The pin goes low on the cycle the count equals the secondary value. Writes to the secondary register are ignored in these modes.
- R9: In PWM a main value of 0 at the period strobe keeps the pin low for the whole following period.
- R10: In mode 111 a high fault input drives the pin low at the next edge and sets the fault status. Both hold until the next control write, which clears the status. Mode 110 ignores the fault input.
- R11: The interrupt flag is set by a mode 001/010/011 match, by a dual-mode fall, by a PWM period strobe, and by a mode 111 fault. It is cleared only by a flag-clear strobe, and a set in the same cycle wins.
- R12: The pin equals the output flip-flop only while the enable bit is 1 and is 0 otherwise. The pin enable output is 1 when the enable bit is 1 and the mode is not 000. Mode 000 holds the flip-flop low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_a | input | 16 | Timer A count |
| tmr_b | input | 16 | Timer B count |
| prd_a | input | 1 | Timer A period-match strobe |
| prd_b | input | 1 | Timer B period-match strobe |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 3 | Mode written with ctl_we |
| ctl_tsel | input | 1 | Timer select written with ctl_we (0 = A, 1 = B) |
| ctl_oe | input | 1 | Output enable bit written with ctl_we |
| pri_we | input | 1 | Main register write strobe |
| pri_data | input | 16 | Main register write data |
| sec_we | input | 1 | Secondary register write strobe |
| sec_data | input | 16 | Secondary register write data |
| fault | input | 1 | Active-high fault input |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| pin | output | 1 | Compare/PWM output |
| pin_oe | output | 1 | Output drive enable |
| irq_flag | output | 1 | Interrupt flag |
| fault_stat | output | 1 | Latched fault status |

## Verification
The output flip-flop, the flag and the fault status all reach the ports one edge after the cycle that changes them, so a wrong state shows within one cycle of the match or strobe that should have moved it. The exception is a slave duty register that loaded at the wrong time or accepted a forbidden write. That error stays hidden until the count reaches the stale value, at most one timer period later, when the PWM falling edge lands in the wrong cycle. A state machine stuck in the wrong state shows as a missing rise, fall or flag on the next match of the register it should be watching.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [2:0] {
        M_OFF   = 3'b000,
        M_HI    = 3'b001,
        M_LO    = 3'b010,
        M_TGL   = 3'b011,
        M_PULSE = 3'b100,
        M_TRAIN = 3'b101,
        M_PWM   = 3'b110,
        M_PWMF  = 3'b111
    } ocp_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_RISE,
        ST_FALL,
        ST_DONE,
        ST_PWM,
        ST_FAULT
    } ocp_state_e;

    function automatic ocp_state_e ocp_init_state(ocp_mode_e m);
        unique case (m)
            M_OFF:                ocp_init_state = ST_OFF;
            M_HI, M_LO, M_TGL:    ocp_init_state = ST_ARM;
            M_PULSE, M_TRAIN:     ocp_init_state = ST_RISE;
            M_PWM, M_PWMF:        ocp_init_state = ST_PWM;
            default:              ocp_init_state = ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/ocp_tsel.sv
module ocp_tsel #(
    parameter int W = 16
) (
    input  logic [W-1:0] tmr_a,
    input  logic [W-1:0] tmr_b,
    input  logic         prd_a,
    input  logic         prd_b,
    input  logic         sel,
    output logic [W-1:0] cnt,
    output logic         prd
);
    always_comb begin
        cnt = sel ? tmr_b : tmr_a;
        prd = sel ? prd_b : prd_a;
    end
endmodule

// File: rtl/ocp_regs.sv
module ocp_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pri_we,
    input  logic [W-1:0] pri_data,
    input  logic         sec_we,
    input  logic [W-1:0] sec_data,
    input  logic         pwm_active,
    input  logic         load,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] pri_q,
    output logic         hit_p,
    output logic         hit_s
);
    localparam int NCMP = 2;

    logic [W-1:0] sec_q;
    logic [W-1:0] ref_v [NCMP];
    logic [NCMP-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_q <= '0;
            sec_q <= '0;
        end else begin
            if (pri_we)
                pri_q <= pri_data;
            if (load)
                sec_q <= pri_q;
            else if (sec_we && !pwm_active)
                sec_q <= sec_data;
        end
    end

    assign ref_v[0] = pri_q;
    assign ref_v[1] = sec_q;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign hit[i] = (cnt == ref_v[i]);
    end

    assign hit_p = hit[0];
    assign hit_s = hit[1];

    // R8
    slave_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_active && !load) |=> $stable(sec_q));
endmodule

// File: rtl/ocp_fsm.sv
module ocp_fsm
    import ocp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_we,
    input  ocp_mode_e new_mode,
    input  ocp_mode_e mode,
    input  logic      fault,
    input  logic      flag_clr,
    input  logic      hit_p,
    input  logic      hit_s,
    input  logic      prd,
    input  logic      pri_zero,
    output logic      q_q,
    output logic      flag_q,
    output logic      fault_st_q,
    output logic      load
);
    ocp_state_e st_q, st_d;
    logic q_d, fs_d, ev;
    logic fault_hit;

    assign fault_hit = fault && (mode == M_PWMF);
    assign load      = (st_q == ST_PWM) && prd && !ctl_we && !fault_hit;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d = ocp_init_state(new_mode);
        end else begin
            unique case (st_q)
                ST_OFF:   st_d = ST_OFF;
                ST_ARM:   if (hit_p && (mode == M_HI || mode == M_LO)) st_d = ST_DONE;
                ST_RISE:  if (hit_s) st_d = ST_FALL;
                ST_FALL:  if (hit_p) st_d = (mode == M_TRAIN) ? ST_RISE : ST_DONE;
                ST_DONE:  st_d = ST_DONE;
                ST_PWM:   if (fault_hit) st_d = ST_FAULT;
                ST_FAULT: st_d = ST_FAULT;
                default:  st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        q_d  = q_q;
        fs_d = fault_st_q;
        ev   = 1'b0;
        if (ctl_we) begin
            q_d  = (new_mode == M_LO);
            fs_d = 1'b0;
        end else begin
            unique case (st_q)
                ST_OFF: q_d = 1'b0;
                ST_ARM: if (hit_p) begin
                    ev = 1'b1;
                    if (mode == M_HI)      q_d = 1'b1;
                    else if (mode == M_LO) q_d = 1'b0;
                    else                   q_d = ~q_q;
                end
                ST_RISE: if (hit_s) q_d = 1'b1;
                ST_FALL: if (hit_p) begin
                    q_d = 1'b0;
                    ev  = 1'b1;
                end
                ST_DONE: q_d = q_q;
                ST_PWM: begin
                    if (fault_hit) begin
                        q_d  = 1'b0;
                        fs_d = 1'b1;
                        ev   = 1'b1;
                    end else if (prd) begin
                        q_d = !pri_zero;
                        ev  = 1'b1;
                    end else if (hit_s) begin
                        q_d = 1'b0;
                    end
                end
                ST_FAULT: q_d = 1'b0;
                default:  q_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q        <= 1'b0;
            flag_q     <= 1'b0;
            fault_st_q <= 1'b0;
        end else begin
            q_q        <= q_d;
            fault_st_q <= fs_d;
            flag_q     <= ev | (flag_q & ~flag_clr);
        end
    end

    // R10
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PWM && fault_hit && !ctl_we) |=> (!q_q && fault_st_q));
    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    // R8
    pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PWM && !prd && !ctl_we && !q_q) |=> !q_q);
    // R6
    pulse_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && mode == M_PULSE && !ctl_we) |=> !q_q);
    // R12
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |-> !q_q);
endmodule

// File: rtl/oc_pwm_channel.sv
module oc_pwm_channel
    import ocp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tmr_a,
    input  logic [W-1:0] tmr_b,
    input  logic         prd_a,
    input  logic         prd_b,
    input  logic         ctl_we,
    input  logic [2:0]   ctl_mode,
    input  logic         ctl_tsel,
    input  logic         ctl_oe,
    input  logic         pri_we,
    input  logic [W-1:0] pri_data,
    input  logic         sec_we,
    input  logic [W-1:0] sec_data,
    input  logic         fault,
    input  logic         flag_clr,
    output logic         pin,
    output logic         pin_oe,
    output logic         irq_flag,
    output logic         fault_stat
);
    ocp_mode_e    mode_r;
    logic         tsel_r, oe_r;
    logic [W-1:0] cnt, pri_q;
    logic         prd, hit_p, hit_s, load, q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r <= M_OFF;
            tsel_r <= 1'b0;
            oe_r   <= 1'b0;
        end else if (ctl_we) begin
            mode_r <= ocp_mode_e'(ctl_mode);
            tsel_r <= ctl_tsel;
            oe_r   <= ctl_oe;
        end
    end

    ocp_tsel #(.W(W)) u_tsel (
        .tmr_a(tmr_a), .tmr_b(tmr_b), .prd_a(prd_a), .prd_b(prd_b),
        .sel(tsel_r), .cnt(cnt), .prd(prd)
    );

    ocp_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .pri_we(pri_we), .pri_data(pri_data),
        .sec_we(sec_we), .sec_data(sec_data),
        .pwm_active(mode_r == M_PWM || mode_r == M_PWMF),
        .load(load), .cnt(cnt), .pri_q(pri_q),
        .hit_p(hit_p), .hit_s(hit_s)
    );

    ocp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we),
        .new_mode(ocp_mode_e'(ctl_mode)), .mode(mode_r),
        .fault(fault), .flag_clr(flag_clr),
        .hit_p(hit_p), .hit_s(hit_s), .prd(prd),
        .pri_zero(pri_q == '0),
        .q_q(q), .flag_q(irq_flag), .fault_st_q(fault_stat), .load(load)
    );

    assign pin    = q & oe_r;
    assign pin_oe = oe_r & (mode_r != M_OFF);

    // R10
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stat && !ctl_we) |=> fault_stat);
endmodule

// File: tb/oc_pwm_channel_test.sv
module oc_pwm_channel_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [15:0] tmr_a = '0, tmr_b = '0, per_a = 16'd20, per_b = 16'd20;
    logic        run_a = 1'b1, run_b = 1'b1;
    logic        prd_a, prd_b;
    logic        ctl_we = 0, ctl_tsel = 0, ctl_oe = 0;
    logic [2:0]  ctl_mode = 0;
    logic        pri_we = 0, sec_we = 0, fault = 0, flag_clr = 0;
    logic [15:0] pri_data = 0, sec_data = 0;
    logic        pin, pin_oe, irq_flag, fault_stat;

    assign prd_a = run_a && (tmr_a == per_a);
    assign prd_b = run_b && (tmr_b == per_b);

    oc_pwm_channel uut (
        .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .prd_a(prd_a), .prd_b(prd_b), .ctl_we(ctl_we), .ctl_mode(ctl_mode),
        .ctl_tsel(ctl_tsel), .ctl_oe(ctl_oe), .pri_we(pri_we), .pri_data(pri_data),
        .sec_we(sec_we), .sec_data(sec_data), .fault(fault), .flag_clr(flag_clr),
        .pin(pin), .pin_oe(pin_oe), .irq_flag(irq_flag), .fault_stat(fault_stat)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // expected-behaviour model, states: 0 off 1 arm 2 rise 3 fall 4 done 5 pwm 6 fault
    int          m_st = 0;
    logic [2:0]  m_mode = 0;
    logic        m_tsel = 0, m_oe = 0, m_q = 0, m_flag = 0, m_fs = 0;
    logic [15:0] m_pri = 0, m_sec = 0;

    function automatic int init_st(logic [2:0] m);
        if (m == 0) return 0;
        if (m <= 3) return 1;
        if (m <= 5) return 2;
        return 5;
    endfunction

    function automatic string mode_tag(logic [2:0] m);
        case (m)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6, 3'd7: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [15:0] cnt;
        logic prd, hp, hs, ev, ld, fh;
        logic [15:0] npri, nsec;
        cnt = m_tsel ? tmr_b : tmr_a;
        prd = m_tsel ? prd_b : prd_a;
        hp = (cnt == m_pri);
        hs = (cnt == m_sec);
        ev = 0;
        ld = 0;
        fh = fault && (m_mode == 3'd7);
        npri = pri_we ? pri_data : m_pri;
        nsec = m_sec;
        if (m_st == 5 && prd && !ctl_we && !fh) ld = 1;
        if (ld) nsec = m_pri;
        else if (sec_we && m_mode < 3'd6) nsec = sec_data;
        if (ctl_we) begin
            m_st = init_st(ctl_mode);
            m_q = (ctl_mode == 3'd2);
            m_fs = 0;
            m_mode = ctl_mode;
            m_tsel = ctl_tsel;
            m_oe = ctl_oe;
        end else begin
            case (m_st)
                0: m_q = 0;
                1: if (hp) begin
                    ev = 1;
                    if (m_mode == 3'd1) begin m_q = 1; m_st = 4; end
                    else if (m_mode == 3'd2) begin m_q = 0; m_st = 4; end
                    else m_q = ~m_q;
                end
                2: if (hs) begin m_q = 1; m_st = 3; end
                3: if (hp) begin
                    m_q = 0; ev = 1;
                    m_st = (m_mode == 3'd5) ? 2 : 4;
                end
                5: begin
                    if (fh) begin m_q = 0; m_fs = 1; ev = 1; m_st = 6; end
                    else if (prd) begin m_q = (m_pri != 0); ev = 1; end
                    else if (hs) m_q = 0;
                end
                6: m_q = 0;
                default: ;
            endcase
        end
        m_flag = ev | (m_flag & ~flag_clr);
        m_pri = npri;
        m_sec = nsec;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        if (run_a) tmr_a = (tmr_a >= per_a) ? 16'd0 : tmr_a + 16'd1;
        if (run_b) tmr_b = (tmr_b >= per_b) ? 16'd0 : tmr_b + 16'd1;
        chk(mode_tag(m_mode), "pin", pin, m_q & m_oe);
        chk("R12", "pin_oe", pin_oe, m_oe && (m_mode != 0));
        chk("R11", "irq_flag", irq_flag, m_flag);
        chk("R10", "fault_stat", fault_stat, m_fs);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_ctl(logic [2:0] m, logic ts, logic oe);
        ctl_mode = m; ctl_tsel = ts; ctl_oe = oe; ctl_we = 1;
        tick();
        ctl_we = 0;
    endtask

    task automatic wr_pri(logic [15:0] v);
        pri_data = v; pri_we = 1; tick(); pri_we = 0;
    endtask

    task automatic wr_sec(logic [15:0] v);
        sec_data = v; sec_we = 1; tick(); sec_we = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "pin", pin, 0);
        chk("R1", "pin_oe", pin_oe, 0);
        chk("R1", "irq_flag", irq_flag, 0);
        chk("R1", "fault_stat", fault_stat, 0);
        rst_n = 1;
        ticks(2);

        // R2: timer B selected and held, timer A matching must not matter
        run_b = 0; tmr_b = 16'd0;
        wr_pri(16'd5);
        set_ctl(3'd1, 1'b1, 1'b1);
        ticks(30);
        chk("R2", "pin held by idle timer B", pin, 1'b0);
        run_b = 1;
        ticks(25);
        chk("R2", "pin after timer B match", pin, 1'b1);

        // R12: enable off hides the output
        set_ctl(3'd2, 1'b0, 1'b0);
        ticks(3);
        chk("R12", "pin with enable off", pin, 1'b0);

        // R9: zero duty in PWM keeps the pin low for a full period
        wr_pri(16'd0);
        set_ctl(3'd6, 1'b0, 1'b1);
        ticks(25);
        for (int i = 0; i < 21; i++) begin
            tick();
            chk("R9", "zero duty pin", pin, 1'b0);
        end

        // R8: secondary write in PWM ignored; duty 8 then observed edge
        wr_pri(16'd8);
        wr_sec(16'd3);
        ticks(45);

        // R10: mode 110 ignores fault, mode 111 latches it
        fault = 1; ticks(5); fault = 0;
        chk("R10", "fault ignored in 110", fault_stat, 1'b0);
        set_ctl(3'd7, 1'b0, 1'b1);
        ticks(22);
        fault = 1; tick(); fault = 0;
        chk("R10", "fault latched", fault_stat, 1'b1);
        chk("R10", "pin after fault", pin, 1'b0);
        ticks(30);
        set_ctl(3'd7, 1'b0, 1'b1);
        chk("R10", "status cleared by mode write", fault_stat, 1'b0);

        // R11: flag holds until cleared
        ticks(25);
        chk("R11", "flag set by period", irq_flag, 1'b1);
        flag_clr = 1; tick(); flag_clr = 0;

        // R6/R7 directed pulses
        set_ctl(3'd0, 1'b0, 1'b1);
        wr_sec(16'd4); wr_pri(16'd12);
        set_ctl(3'd4, 1'b0, 1'b1);
        ticks(50);
        set_ctl(3'd5, 1'b0, 1'b1);
        ticks(50);
        set_ctl(3'd3, 1'b0, 1'b1);
        ticks(50);

        // constrained random rounds
        for (int r = 0; r < 60; r++) begin
            per_a = 16'(8 + $urandom_range(0, 32));
            per_b = 16'(8 + $urandom_range(0, 32));
            set_ctl(3'd0, 1'b0, 1'b1);
            wr_sec(16'($urandom_range(0, 40)));
            wr_pri(16'($urandom_range(0, 44)));
            set_ctl(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 7) != 0));
            for (int k = 0; k < 150; k++) begin
                fault    = ($urandom_range(0, 39) == 0);
                flag_clr = ($urandom_range(0, 19) == 0);
                if ($urandom_range(0, 29) == 0) begin
                    pri_we = 1; pri_data = 16'($urandom_range(0, 44));
                end
                if ($urandom_range(0, 29) == 0) begin
                    sec_we = 1; sec_data = 16'($urandom_range(0, 40));
                end
                tick();
                fault = 0; flag_clr = 0; pri_we = 0; sec_we = 0;
            end
        end
        finish_run();
    end
endmodule